// File: doc/BRIEF.md
# Configuration Security Access Gate

This block sits between the configuration interfaces of a programmable device and its configuration registers and memory. It decides whether each readback beat, register write, incoming stream load and key-entry request may go ahead. It bases that decision on a small amount of held state:
- the security level, a sticky 2-bit code;
- whether the most recent accepted stream was encrypted;
- whether a key has been stored;
- whether the key has been locked.

All grant and deny outputs are combinational from that registered state and the request inputs. A requester therefore learns the outcome in the same cycle it asks.

Readback data flows through the gate on a valid/ready channel. The gate adds no storage and no stall of its own. `rb_in_ready` follows `rb_out_ready`, and `rb_out_valid` follows `rb_in_valid`, so back-pressure passes straight through and a beat moves only when both valid and ready are high. A denied beat still completes the handshake, but with all-zero data. Register writes are plain strobes: a denied write never reaches `reg_we`. Any denial raises a registered violation pulse. The stored key never appears on any output data path. Key entry first wipes configuration memory and the key, and a locked key can only be replaced after a full device clear.

Top module: `cfg_sec_gate`

## Requirements
- R1: A stream start with `stream_enc`=1 is accepted only when a key is present and `stream_width` is 0 (x1) or 3 (x8). Codes 1 (x2), 2 (x4), 4 (x16) and 5..7 are rejected. An unencrypted stream is accepted for codes 0..4 and rejected for 5..7. Accept and reject are valid in the same cycle as `stream_start`.
- R2: After an accepted encrypted stream, readback on port 0 (JTAG) and port 1 (parallel) is denied at every security level. Port 2 (internal) follows the level rule.
- R3: After an accepted unencrypted stream, readback depends only on the security level, even while a key is present.
- R4: Level 0 grants readback on ports 0, 1 and 2. Level 1 grants only port 2. Level 2 grants none. Port code 3 is never granted.
- R5: At level 3, all readback is denied. Only writes to address 0 (CRC) or address 4 (command) are granted; every other address is denied.
- R6: A granted readback beat carries `rb_in_data` to `rb_out_data`. A denied beat carries all zeros. `rb_in_ready` equals `rb_out_ready`, and `rb_out_valid` equals `rb_in_valid`.
- R7: `violation` is high in the cycle after any of the following, and low otherwise:
  - a denied readback handshake;
  - a denied write;
  - a rejected stream start;
  - a denied key-entry request.
- R8: An accepted key-entry request clears the stored key and the encryption history at the next clock edge. `mem_clear` is high for exactly the following cycle, and the block is then in key mode until `key_exit`. A `key_load` in key mode sets `key_present`.
- R9: Leaving key mode with `key_lock_in`=1 locks the key. While locked, every key-entry request is denied and memory is not cleared. Only `dev_clear` removes the lock.
- R10: After reset or `dev_clear`, the level is 0. A granted write to address 5 with data bits [1:0] sets the level only while it is 0. A non-zero level changes only through `dev_clear`.
- R11: A denied write leaves `reg_we` low and `reg_wdata` zero. A granted write drives `reg_we` high and passes `wr_data` through in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_clear | input | 1 | Full device clear: level, history, key and lock |
| stream_start | input | 1 | Strobe: a configuration stream begins |
| stream_enc | input | 1 | Stream is encrypted |
| stream_width | input | 3 | Data-width code 0=x1 1=x2 2=x4 3=x8 4=x16 |
| stream_accept | output | 1 | Stream may load |
| stream_reject | output | 1 | Stream refused |
| rb_port | input | 2 | Readback source 0=JTAG 1=parallel 2=internal |
| rb_in_valid | input | 1 | Readback beat from memory valid |
| rb_in_ready | output | 1 | Gate can take the beat |
| rb_in_data | input | DATA_W | Readback data from memory |
| rb_out_valid | output | 1 | Beat to the requester valid |
| rb_out_ready | input | 1 | Requester can take the beat |
| rb_out_data | output | DATA_W | Readback data, zeroed when denied |
| rb_grant | output | 1 | Readback allowed for this port and state |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address tag |
| wr_data | input | DATA_W | Write data |
| wr_grant | output | 1 | Write allowed |
| reg_we | output | 1 | Write enable to the register file |
| reg_wdata | output | DATA_W | Write data, zero when denied |
| key_prog_req | input | 1 | Request to enter key programming |
| key_load | input | 1 | Store a key while in key mode |
| key_exit | input | 1 | Leave key mode |
| key_lock_in | input | 1 | Lock the key on exit |
| key_entry_deny | output | 1 | Key-entry request refused |
| mem_clear | output | 1 | Configuration memory wipe pulse |
| key_mode | output | 1 | Key programming in progress |
| key_present | output | 1 | A key is stored |
| key_locked | output | 1 | Key is locked |
| sec_level | output | 2 | Current security level |
| violation | output | 1 | Registered pulse after any denial |

## Verification
The bench sweeps every level, every encryption history and every port code. A gate that checks the level but forgets the encryption history would leak readback through JTAG after an encrypted load. A gate that wrongly keeps honouring the history would refuse readback after a plain load while a key is present.

At level 3 it walks all 32 write addresses. A mis-decoded exception would open other registers, or block CRC and command writes. It sweeps all eight width codes with and without encryption and with and without a key. This exposes a width check that admits x2, x4 or x16 encrypted streams.

It also checks four further cases:
- a locked key refusing re-entry without wiping memory;
- key entry erasing the encryption history;
- a non-zero level refusing to be lowered;
- back-pressure passing through without any false violation.

// File: rtl/cfg_sec_pkg.sv
package cfg_sec_pkg;
  typedef enum logic [2:0] {
    BW_X1  = 3'd0,
    BW_X2  = 3'd1,
    BW_X4  = 3'd2,
    BW_X8  = 3'd3,
    BW_X16 = 3'd4
  } bus_w_e;

  typedef enum logic [1:0] {
    PT_JTAG = 2'd0,
    PT_PAR  = 2'd1,
    PT_INT  = 2'd2,
    PT_NONE = 2'd3
  } rb_port_e;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_CLEAR = 2'd1,
    KS_KEY   = 2'd2
  } key_st_e;

  localparam logic [1:0] LVL_OPEN = 2'd0;
  localparam logic [1:0] LVL_INT  = 2'd1;
  localparam logic [1:0] LVL_NORB = 2'd2;
  localparam logic [1:0] LVL_LOCK = 2'd3;
endpackage

// File: rtl/cfg_sec_state.sv
module cfg_sec_state
  import cfg_sec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_clear,
  input  logic       key_prog_req,
  input  logic       key_load,
  input  logic       key_exit,
  input  logic       key_lock_in,
  input  logic       lvl_wr,
  input  logic [1:0] lvl_wdata,
  input  logic       load_ok,
  input  logic       load_enc,
  output logic [1:0] sec_level,
  output logic       enc_loaded,
  output logic       key_present,
  output logic       key_locked,
  output logic       key_mode,
  output logic       mem_clear,
  output logic       entry_deny
);
  key_st_e st;
  logic    entry_ok;

  // Key entry is only possible from idle and with the key unlocked.
  assign entry_ok   = key_prog_req && (st == KS_IDLE) && !key_locked;
  assign entry_deny = key_prog_req && !entry_ok;
  assign key_mode   = (st != KS_IDLE);
  assign mem_clear  = (st == KS_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= KS_IDLE;
      sec_level   <= LVL_OPEN;
      enc_loaded  <= 1'b0;
      key_present <= 1'b0;
      key_locked  <= 1'b0;
    end else if (dev_clear) begin
      st          <= KS_IDLE;
      sec_level   <= LVL_OPEN;
      enc_loaded  <= 1'b0;
      key_present <= 1'b0;
      key_locked  <= 1'b0;
    end else begin
      // Level is sticky once non-zero.
      if (lvl_wr && (sec_level == LVL_OPEN))
        sec_level <= lvl_wdata;

      // Key entry wipes the encryption history; otherwise a load records it.
      if (entry_ok)
        enc_loaded <= 1'b0;
      else if (load_ok)
        enc_loaded <= load_enc;

      unique case (st)
        KS_IDLE: begin
          if (entry_ok) begin
            st          <= KS_CLEAR;
            key_present <= 1'b0;
          end
        end
        KS_CLEAR: st <= KS_KEY;
        KS_KEY: begin
          if (key_exit) begin
            st         <= KS_IDLE;
            key_locked <= key_lock_in;
          end else if (key_load) begin
            key_present <= 1'b1;
          end
        end
        default: st <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_sec_load.sv
module cfg_sec_load
  import cfg_sec_pkg::*;
(
  input  logic       stream_start,
  input  logic       stream_enc,
  input  logic [2:0] stream_width,
  input  logic       key_present,
  output logic       stream_accept,
  output logic       stream_reject
);
  logic width_legal;
  logic width_enc_ok;

  assign width_legal  = (stream_width <= BW_X16);
  assign width_enc_ok = (stream_width == BW_X1) || (stream_width == BW_X8);

  always_comb begin
    stream_accept = 1'b0;
    if (stream_start) begin
      if (stream_enc)
        stream_accept = key_present && width_enc_ok;
      else
        stream_accept = width_legal;
    end
  end

  assign stream_reject = stream_start && !stream_accept;
endmodule

// File: rtl/cfg_sec_rb_path.sv
module cfg_sec_rb_path
  import cfg_sec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sec_level,
  input  logic              enc_loaded,
  input  logic [1:0]        rb_port,
  input  logic              rb_in_valid,
  output logic              rb_in_ready,
  input  logic [DATA_W-1:0] rb_in_data,
  output logic              rb_out_valid,
  input  logic              rb_out_ready,
  output logic [DATA_W-1:0] rb_out_data,
  output logic              rb_grant,
  output logic              rb_denied_xfer
);
  localparam int NUM_PORTS = 4;

  logic [NUM_PORTS-1:0] port_allow;

  // One permission term per port code, chosen by the port's kind.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p == int'(PT_INT)) begin : g_internal
      assign port_allow[p] = (sec_level == LVL_OPEN) || (sec_level == LVL_INT);
    end else if (p == int'(PT_NONE)) begin : g_unused
      assign port_allow[p] = 1'b0;
    end else begin : g_external
      assign port_allow[p] = (sec_level == LVL_OPEN) && !enc_loaded;
    end
  end

  assign rb_grant       = port_allow[rb_port];
  assign rb_out_valid   = rb_in_valid;
  assign rb_in_ready    = rb_out_ready;
  assign rb_out_data    = rb_grant ? rb_in_data : '0;
  assign rb_denied_xfer = rb_in_valid && rb_out_ready && !rb_grant;
endmodule

// File: rtl/cfg_sec_wr_path.sv
module cfg_sec_wr_path
  import cfg_sec_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] CRC_ADDR = 0,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 5
) (
  input  logic [1:0]        sec_level,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_grant,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              lvl_wr,
  output logic [1:0]        lvl_wdata,
  output logic              wr_denied
);
  logic exempt;

  assign exempt    = (wr_addr == CRC_ADDR) || (wr_addr == CMD_ADDR);
  assign wr_grant  = (sec_level != LVL_LOCK) || exempt;
  assign reg_we    = wr_valid && wr_grant;
  assign reg_wdata = reg_we ? wr_data : '0;
  assign lvl_wr    = reg_we && (wr_addr == CTL_ADDR);
  assign lvl_wdata = wr_data[1:0];
  assign wr_denied = wr_valid && !wr_grant;
endmodule

// File: rtl/cfg_sec_gate.sv
module cfg_sec_gate
  import cfg_sec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_clear,
  input  logic              stream_start,
  input  logic              stream_enc,
  input  logic [2:0]        stream_width,
  output logic              stream_accept,
  output logic              stream_reject,
  input  logic [1:0]        rb_port,
  input  logic              rb_in_valid,
  output logic              rb_in_ready,
  input  logic [DATA_W-1:0] rb_in_data,
  output logic              rb_out_valid,
  input  logic              rb_out_ready,
  output logic [DATA_W-1:0] rb_out_data,
  output logic              rb_grant,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_grant,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              key_prog_req,
  input  logic              key_load,
  input  logic              key_exit,
  input  logic              key_lock_in,
  output logic              key_entry_deny,
  output logic              mem_clear,
  output logic              key_mode,
  output logic              key_present,
  output logic              key_locked,
  output logic [1:0]        sec_level,
  output logic              violation
);
  localparam logic [ADDR_W-1:0] CRC_A = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(5);

  logic       enc_loaded;
  logic       lvl_wr;
  logic [1:0] lvl_wdata;
  logic       rb_denied_xfer;
  logic       wr_denied;
  logic       viol_d;

  cfg_sec_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_clear    (dev_clear),
    .key_prog_req (key_prog_req),
    .key_load     (key_load),
    .key_exit     (key_exit),
    .key_lock_in  (key_lock_in),
    .lvl_wr       (lvl_wr),
    .lvl_wdata    (lvl_wdata),
    .load_ok      (stream_accept),
    .load_enc     (stream_enc),
    .sec_level    (sec_level),
    .enc_loaded   (enc_loaded),
    .key_present  (key_present),
    .key_locked   (key_locked),
    .key_mode     (key_mode),
    .mem_clear    (mem_clear),
    .entry_deny   (key_entry_deny)
  );

  cfg_sec_load u_load (
    .stream_start  (stream_start),
    .stream_enc    (stream_enc),
    .stream_width  (stream_width),
    .key_present   (key_present),
    .stream_accept (stream_accept),
    .stream_reject (stream_reject)
  );

  cfg_sec_rb_path #(.DATA_W(DATA_W)) u_rb (
    .sec_level      (sec_level),
    .enc_loaded     (enc_loaded),
    .rb_port        (rb_port),
    .rb_in_valid    (rb_in_valid),
    .rb_in_ready    (rb_in_ready),
    .rb_in_data     (rb_in_data),
    .rb_out_valid   (rb_out_valid),
    .rb_out_ready   (rb_out_ready),
    .rb_out_data    (rb_out_data),
    .rb_grant       (rb_grant),
    .rb_denied_xfer (rb_denied_xfer)
  );

  cfg_sec_wr_path #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CRC_ADDR (CRC_A),
    .CMD_ADDR (CMD_A),
    .CTL_ADDR (CTL_A)
  ) u_wr (
    .sec_level (sec_level),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_grant  (wr_grant),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .lvl_wr    (lvl_wr),
    .lvl_wdata (lvl_wdata),
    .wr_denied (wr_denied)
  );

  assign viol_d = rb_denied_xfer || wr_denied || stream_reject || key_entry_deny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= viol_d;
  end
endmodule

// File: rtl/cfg_sec_gate_chk.sv
module cfg_sec_gate_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_clear,
  input logic              stream_start,
  input logic              stream_enc,
  input logic [2:0]        stream_width,
  input logic              stream_reject,
  input logic [1:0]        rb_port,
  input logic              rb_out_valid,
  input logic [DATA_W-1:0] rb_out_data,
  input logic              rb_grant,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_grant,
  input logic              key_prog_req,
  input logic              key_entry_deny,
  input logic              mem_clear,
  input logic              key_present,
  input logic [1:0]        sec_level,
  input logic              enc_loaded,
  input logic              violation
);
  assert_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_start && stream_enc && stream_width != 3'd0 && stream_width != 3'd3)
      |-> stream_reject);

  assert_enc_rb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_loaded && rb_port != 2'd2) |-> !rb_grant);

  assert_norb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_level[1]) |-> !rb_grant);

  assert_lock_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_level == 2'd3 && wr_valid && wr_addr != ADDR_W'(0) && wr_addr != ADDR_W'(4))
      |-> !wr_grant);

  assert_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_out_valid && !rb_grant) |-> (rb_out_data == '0));

  assert_wr_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_grant) |=> violation);

  assert_entry_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_prog_req && !key_entry_deny && !dev_clear) |=> (mem_clear && !key_present));

  assert_deny_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_entry_deny && !mem_clear && !dev_clear) |=> !mem_clear);

  assert_level_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_level != 2'd0 && !dev_clear) |=> $stable(sec_level));
endmodule

bind cfg_sec_gate cfg_sec_gate_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dev_clear      (dev_clear),
  .stream_start   (stream_start),
  .stream_enc     (stream_enc),
  .stream_width   (stream_width),
  .stream_reject  (stream_reject),
  .rb_port        (rb_port),
  .rb_out_valid   (rb_out_valid),
  .rb_out_data    (rb_out_data),
  .rb_grant       (rb_grant),
  .wr_valid       (wr_valid),
  .wr_addr        (wr_addr),
  .wr_grant       (wr_grant),
  .key_prog_req   (key_prog_req),
  .key_entry_deny (key_entry_deny),
  .mem_clear      (mem_clear),
  .key_present    (key_present),
  .sec_level      (sec_level),
  .enc_loaded     (enc_loaded),
  .violation      (violation)
);

// File: tb/cfg_sec_gate_tb.sv
`timescale 1ns/1ps
module cfg_sec_gate_tb;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic dev_clear = 0;
  logic stream_start = 0, stream_enc = 0;
  logic [2:0] stream_width = 0;
  logic stream_accept, stream_reject;
  logic [1:0] rb_port = 0;
  logic rb_in_valid = 0, rb_in_ready, rb_out_valid, rb_out_ready = 0;
  logic [DW-1:0] rb_in_data = 0, rb_out_data;
  logic rb_grant;
  logic wr_valid = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic wr_grant, reg_we;
  logic [DW-1:0] reg_wdata;
  logic key_prog_req = 0, key_load = 0, key_exit = 0, key_lock_in = 0;
  logic key_entry_deny, mem_clear, key_mode, key_present, key_locked;
  logic [1:0] sec_level;
  logic violation;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  cfg_sec_gate #(.DATA_W(DW), .ADDR_W(AW)) u_dut (.*);

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic logic exp_rb(input int lvl, input int enc, input int port);
    if (port == 3 || lvl >= 2) return 1'b0;
    if (lvl == 1) return port == 2;
    return (port == 2) || (enc == 0);
  endfunction

  task automatic pulse_clear();
    dev_clear = 1; tick(); dev_clear = 0;
  endtask

  task automatic key_enter(input logic lock);
    key_prog_req = 1; tick(); key_prog_req = 0;
    tick();
    key_load = 1; tick(); key_load = 0;
    key_exit = 1; key_lock_in = lock; tick(); key_exit = 0; key_lock_in = 0;
  endtask

  task automatic load(input logic enc, input logic [2:0] w);
    stream_start = 1; stream_enc = enc; stream_width = w; tick();
    stream_start = 0; stream_enc = 0; stream_width = 0;
  endtask

  task automatic set_level(input logic [1:0] l);
    wr_valid = 1; wr_addr = 5; wr_data = {30'd0, l}; tick();
    wr_valid = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic prep(input int lvl, input int enc);
    pulse_clear();
    key_enter(1'b0);
    load(enc[0], 3'd0);
    set_level(lvl[1:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // Reset state
    check("R10 reset level", DW'(sec_level), 0);
    check("R7 reset violation", DW'(violation), 0);
    check("R8 reset key_present", DW'(key_present), 0);
    check("R8 reset mem_clear", DW'(mem_clear), 0);
    check("R9 reset key_locked", DW'(key_locked), 0);

    // R1: stream sweep without key
    for (int e = 0; e < 2; e++) begin
      for (int w = 0; w < 8; w++) begin
        logic expa;
        expa = (e == 0) ? (w <= 4) : 1'b0;
        stream_start = 1; stream_enc = e[0]; stream_width = w[2:0];
        #1;
        check($sformatf("R1 nokey enc%0d w%0d accept", e, w), DW'(stream_accept), DW'(expa));
        check($sformatf("R1 nokey enc%0d w%0d reject", e, w), DW'(stream_reject), DW'(!expa));
        tick();
        stream_start = 0;
        check($sformatf("R7 stream viol enc%0d w%0d", e, w), DW'(violation), DW'(!expa));
      end
    end

    // R8: key entry
    key_prog_req = 1; #1;
    check("R8 entry not denied", DW'(key_entry_deny), 0);
    tick(); key_prog_req = 0;
    check("R8 mem_clear pulse", DW'(mem_clear), 1);
    check("R8 key cleared", DW'(key_present), 0);
    check("R8 key mode", DW'(key_mode), 1);
    tick();
    check("R8 mem_clear one cycle", DW'(mem_clear), 0);
    key_load = 1; tick(); key_load = 0;
    check("R8 key stored", DW'(key_present), 1);
    key_exit = 1; tick(); key_exit = 0;
    check("R8 key mode left", DW'(key_mode), 0);

    // R1: encrypted sweep with key
    for (int w = 0; w < 8; w++) begin
      stream_start = 1; stream_enc = 1; stream_width = w[2:0];
      #1;
      check($sformatf("R1 key enc w%0d accept", w), DW'(stream_accept), DW'(w == 0 || w == 3));
      tick();
      stream_start = 0; stream_enc = 0;
    end

    // R2/R3/R4/R5/R6: readback sweep
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int enc = 0; enc < 2; enc++) begin
        prep(lvl, enc);
        check($sformatf("R10 level set %0d", lvl), DW'(sec_level), DW'(lvl));
        for (int p = 0; p < 4; p++) begin
          logic g;
          logic [DW-1:0] d;
          g = exp_rb(lvl, enc, p);
          d = 32'hA5C3_0000 | DW'(lvl * 16 + enc * 4 + p + 1);
          rb_port = p[1:0]; rb_in_data = d; rb_in_valid = 1; rb_out_ready = 1;
          #1;
          check($sformatf("R4 R2 R3 R5 grant l%0d e%0d p%0d", lvl, enc, p), DW'(rb_grant), DW'(g));
          check($sformatf("R6 data l%0d e%0d p%0d", lvl, enc, p), rb_out_data, g ? d : '0);
          check("R6 ready pass", DW'(rb_in_ready), 1);
          tick();
          rb_in_valid = 0;
          check($sformatf("R7 rb viol l%0d e%0d p%0d", lvl, enc, p), DW'(violation), DW'(!g));
        end
        // Back-pressure: no handshake, no violation
        rb_port = 2'd0; rb_in_valid = 1; rb_out_ready = 0;
        #1;
        check("R6 ready follows", DW'(rb_in_ready), 0);
        check("R6 valid follows", DW'(rb_out_valid), 1);
        tick();
        rb_in_valid = 0;
        check("R7 no viol on stall", DW'(violation), 0);
      end
    end

    // R5/R11: level 3 write sweep over all addresses
    prep(3, 0);
    for (int a = 0; a < 32; a++) begin
      logic g;
      g = (a == 0 || a == 4);
      wr_valid = 1; wr_addr = a[AW-1:0]; wr_data = 32'h1234_0000 + DW'(a);
      #1;
      check($sformatf("R5 wr grant a%0d", a), DW'(wr_grant), DW'(g));
      check($sformatf("R11 reg_we a%0d", a), DW'(reg_we), DW'(g));
      check($sformatf("R11 wdata a%0d", a), reg_wdata, g ? 32'h1234_0000 + DW'(a) : '0);
      tick();
      wr_valid = 0;
      check($sformatf("R7 wr viol a%0d", a), DW'(violation), DW'(!g));
    end
    check("R10 level 3 kept", DW'(sec_level), 3);

    // R10: sticky level
    prep(1, 0);
    set_level(2'd3);
    check("R10 level not raised", DW'(sec_level), 1);
    set_level(2'd0);
    check("R10 level not lowered", DW'(sec_level), 1);
    pulse_clear();
    check("R10 dev_clear resets", DW'(sec_level), 0);

    // R8: key entry erases encryption history
    prep(0, 1);
    rb_port = 0; #1;
    check("R2 jtag denied after enc", DW'(rb_grant), 0);
    key_enter(1'b0);
    #1;
    check("R8 history cleared, jtag granted", DW'(rb_grant), 1);

    // R9: lock
    pulse_clear();
    key_enter(1'b1);
    check("R9 locked", DW'(key_locked), 1);
    key_prog_req = 1; #1;
    check("R9 entry denied", DW'(key_entry_deny), 1);
    tick(); key_prog_req = 0;
    check("R9 no mem_clear", DW'(mem_clear), 0);
    check("R9 key kept", DW'(key_present), 1);
    check("R7 entry viol", DW'(violation), 1);
    pulse_clear();
    check("R9 unlock by clear", DW'(key_locked), 0);
    key_prog_req = 1; #1;
    check("R9 entry allowed after clear", DW'(key_entry_deny), 0);
    tick(); key_prog_req = 0;
    check("R8 mem_clear after clear", DW'(mem_clear), 1);
    tick();

    finish_run();
  end
endmodule